// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block decides when the processor core must be forced into a subroutine call to an interrupt service vector. Five request flags come in: external request 0, timer 0 overflow, external request 1, timer 1 overflow and the serial unit. The core supplies an enable byte, a priority byte and a strobe that marks each machine-cycle boundary. It also reports whether the current cycle is the last one of an instruction, and whether that instruction is a return-from-interrupt or a write to the enable or priority byte.

Flags are latched at one strobe and judged at the next. When an enabled, sampled request wins arbitration and nothing blocks it, the block emits a one-cycle call request carrying the source index and its vector address. It also keeps one in-service bit per priority level, so that a running routine is protected from requests of equal or lower level. Nothing is held over: a request that is blocked during its polling cycle is dropped, and only a flag still present at a later sampling strobe can produce a call.

Top module: `vec_irq_arbiter`

## Requirements
- R1: While reset is asserted and right after it is released, `call_req` is 0 and `act_lvl` is 2'b00.
- R2: A flag is captured on a clock edge where `cyc_stb` is 1, and it is judged on the next edge where `cyc_stb` is 1. `call_req` rises in the clock after that polling edge. A flag seen only on the polling edge itself does not produce a call on that edge.
- R3: A source takes part only when its own enable bit (`en_reg` bit 0..4, in the source order of R8) is set and the global enable `en_reg[7]` is set.
- R4: No call is issued on a polling edge where `last_cyc` is 0.
- R5: No call is issued on a polling edge where `instr_reti` or `instr_cfg_wr` is 1.
- R6: There is no pending memory. If a flag is blocked on its polling edge and is gone by the next sampling edge, no call is ever issued for it.
- R7: A set bit in `pri_reg` (bits 0..4, same order as R8) makes that source high level. A high-level candidate is chosen over any low-level candidate.
- R8: Within one level, ties are resolved by fixed index order, lowest index first: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial unit.
- R9: A low-level request is accepted only when `act_lvl` is 2'b00. A high-level request is accepted only when `act_lvl[1]` is 0.
- R10: An issued call sets `act_lvl[level]`, where bit 1 is high and bit 0 is low. A `reti_exec` pulse clears the highest set bit of `act_lvl`. When both happen in the same cycle, the clear is applied before the set.
- R11: `call_req` is a single-clock pulse. `call_idx` is the winning index, and `call_vec` equals 8'h03 + 8 × index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | Machine-cycle boundary strobe: sampling and polling edge |
| irq_flags | input | 5 | Raw request flags, index order of R8 |
| en_reg | input | 8 | Enable byte: bit 7 global, bits 4..0 per source |
| pri_reg | input | 8 | Priority byte: bits 4..0 select high level |
| last_cyc | input | 1 | Current machine cycle ends the instruction |
| instr_reti | input | 1 | Instruction in progress is a return-from-interrupt |
| instr_cfg_wr | input | 1 | Instruction in progress writes the enable or priority byte |
| reti_exec | input | 1 | Pulse: a return-from-interrupt has completed |
| call_req | output | 1 | One-cycle forced-call request |
| call_idx | output | 3 | Index of the source being called |
| call_vec | output | 8 | Service vector address |
| act_lvl | output | 2 | In-service bits: bit 1 high level, bit 0 low level |

## Verification
Single flags at one level show the one-strobe lag between sampling and polling. Stacked flags at one level, and then at mixed levels, separate the fixed tie order from the level preference. Flags held across blocked polling edges are compared with flags dropped before the blocking lifts, which shows whether a blocked request is remembered. Nested sequences, with a low routine and then a high routine in service, show whether preemption follows the level rules and whether `reti_exec` clears the right in-service bit. A long random run with sparse strobes and random blocking is compared every clock with a behavioural model.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int unsigned IDX_W = 3;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;

  typedef struct packed {
    logic             vld;
    logic [IDX_W-1:0] idx;
  } pick_t;

endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int unsigned N_SRC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [N_SRC-1:0] flags_i,
  output logic [N_SRC-1:0] smp_o
);

  logic [N_SRC-1:0] smp_q, smp_d;

  always_comb begin
    smp_d = smp_q;
    if (cap_en) smp_d = flags_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= smp_d;
  end

  assign smp_o = smp_q;

  AST_SMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(smp_o)); // R2

endmodule

// File: rtl/irq_first_set.sv
module irq_first_set
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_SRC = 5
) (
  input  logic [N_SRC-1:0] req_i,
  output pick_t            pick_o
);

  always_comb begin
    pick_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        pick_o.vld = 1'b1;
        pick_o.idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_level_tracker.sv
module irq_level_tracker
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_i,
  input  lvl_e       set_lvl_i,
  input  logic       clr_i,
  output logic [1:0] insvc_o
);

  logic [1:0] insvc_q, insvc_d;

  always_comb begin
    insvc_d = insvc_q;
    if (clr_i) begin
      if (insvc_d[LVL_HI]) insvc_d[LVL_HI] = 1'b0;
      else                 insvc_d[LVL_LO] = 1'b0;
    end
    if (set_i) insvc_d[set_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) insvc_q <= 2'b00;
    else        insvc_q <= insvc_d;
  end

  assign insvc_o = insvc_q;

  AST_SET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> insvc_o[$past(set_lvl_i)]); // R10

  AST_CLR_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && insvc_o[1]) |=> (!insvc_o[1] && insvc_o[0] == $past(insvc_o[0]))); // R10

endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_SRC      = 5,
  parameter int unsigned GEN_BIT    = 7,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_stb,
  input  logic [4:0]       irq_flags,
  input  logic [7:0]       en_reg,
  input  logic [7:0]       pri_reg,
  input  logic             last_cyc,
  input  logic             instr_reti,
  input  logic             instr_cfg_wr,
  input  logic             reti_exec,
  output logic             call_req,
  output logic [2:0]       call_idx,
  output logic [7:0]       call_vec,
  output logic [1:0]       act_lvl
);

  localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] STEP_V = VEC_W'(VEC_STRIDE);

  logic [N_SRC-1:0] smp, cand, hi_req, lo_req;
  pick_t            hi_pick, lo_pick;
  logic [1:0]       insvc;
  logic             hi_ok, lo_ok, sel_vld, no_block, fire;
  logic [IDX_W-1:0] sel_idx;
  lvl_e             sel_lvl;

  irq_sampler #(.N_SRC(N_SRC)) u_smp (
    .clk(clk), .rst_n(rst_n), .cap_en(cyc_stb),
    .flags_i(irq_flags[N_SRC-1:0]), .smp_o(smp)
  );

  always_comb begin
    cand   = smp & en_reg[N_SRC-1:0] & {N_SRC{en_reg[GEN_BIT]}};
    hi_req = cand & pri_reg[N_SRC-1:0];
    lo_req = cand & ~pri_reg[N_SRC-1:0];
  end

  irq_first_set #(.N_SRC(N_SRC)) u_hi (.req_i(hi_req), .pick_o(hi_pick));
  irq_first_set #(.N_SRC(N_SRC)) u_lo (.req_i(lo_req), .pick_o(lo_pick));

  always_comb begin
    hi_ok    = hi_pick.vld && !insvc[LVL_HI];
    lo_ok    = lo_pick.vld && (insvc == 2'b00);
    sel_vld  = hi_ok || lo_ok;
    sel_idx  = hi_ok ? hi_pick.idx : lo_pick.idx;
    sel_lvl  = hi_ok ? LVL_HI : LVL_LO;
    no_block = last_cyc && !instr_reti && !instr_cfg_wr;
    fire     = cyc_stb && sel_vld && no_block;
  end

  irq_level_tracker u_lvl (
    .clk(clk), .rst_n(rst_n), .set_i(fire), .set_lvl_i(sel_lvl),
    .clr_i(reti_exec), .insvc_o(insvc)
  );

  logic             req_q, req_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  always_comb begin
    req_d = fire;
    idx_d = idx_q;
    vec_d = vec_q;
    if (fire) begin
      idx_d = sel_idx;
      vec_d = BASE_V + VEC_W'(sel_idx) * STEP_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      idx_q <= '0;
      vec_q <= '0;
    end else begin
      req_q <= req_d;
      idx_q <= idx_d;
      vec_q <= vec_d;
    end
  end

  assign call_req = req_q;
  assign call_idx = idx_q;
  assign call_vec = vec_q;
  assign act_lvl  = insvc;

  AST_CALL_LAST_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(cyc_stb && last_cyc)); // R4

  AST_CALL_NOT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(!instr_reti && !instr_cfg_wr)); // R5

  AST_CALL_GLOBAL_EN: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(en_reg[GEN_BIT])); // R3

  AST_HI_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(insvc[LVL_HI])); // R9

  AST_CALL_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_idx < IDX_W'(N_SRC))); // R8

  AST_CALL_SETS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (act_lvl != 2'b00)); // R10

endmodule

// File: tb/tb_vec_irq_arbiter.sv
module tb_vec_irq_arbiter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_stb, last_cyc, instr_reti, instr_cfg_wr, reti_exec;
  logic [4:0] irq_flags;
  logic [7:0] en_reg, pri_reg;
  logic       call_req;
  logic [2:0] call_idx;
  logic [7:0] call_vec;
  logic [1:0] act_lvl;

  always #2 clk = ~clk;

  vec_irq_arbiter dut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .irq_flags(irq_flags),
    .en_reg(en_reg), .pri_reg(pri_reg), .last_cyc(last_cyc),
    .instr_reti(instr_reti), .instr_cfg_wr(instr_cfg_wr), .reti_exec(reti_exec),
    .call_req(call_req), .call_idx(call_idx), .call_vec(call_vec), .act_lvl(act_lvl)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string tag   = "R1";

  // behavioural reference
  bit [4:0] m_smp;
  bit [1:0] m_ins;
  bit       m_call;
  int       m_idx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_smp = 0; m_ins = 0; m_call = 0; m_idx = 0;
    end else begin
      int pick, lvl;
      bit fire;
      pick = -1; lvl = 0; fire = 0;
      if (cyc_stb) begin
        for (int L = 1; L >= 0; L--) begin
          for (int s = 0; s < 5; s++) begin
            if (pick < 0 && m_smp[s] && en_reg[s] && en_reg[7] && (int'(pri_reg[s]) == L)) begin
              if ((L == 1 && !m_ins[1]) || (L == 0 && m_ins == 0)) begin
                pick = s; lvl = L;
              end
            end
          end
        end
        fire = (pick >= 0) && last_cyc && !instr_reti && !instr_cfg_wr;
      end
      if (reti_exec) begin
        if (m_ins[1]) m_ins[1] = 0;
        else          m_ins[0] = 0;
      end
      m_call = fire;
      if (fire) begin
        m_ins[lvl] = 1;
        m_idx = pick;
      end
      if (cyc_stb) m_smp = irq_flags;
    end
  end

  task automatic compare();
    n_vec++;
    if (call_req !== m_call || act_lvl !== m_ins ||
        (m_call && (call_idx !== 3'(m_idx) || call_vec !== 8'(3 + 8 * m_idx)))) begin
      n_bad++;
      $display("FAIL %s: req/idx/vec/lvl = %0d/%0d/%0h/%0b expected %0d/%0d/%0h/%0b",
               tag, call_req, call_idx, call_vec, act_lvl,
               m_call, m_idx, 3 + 8 * m_idx, m_ins);
    end
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  // drive at a falling edge, advance one cycle, compare at the next falling edge
  task automatic step(input bit [4:0] f, input bit s, input bit l,
                      input bit r, input bit w, input bit x);
    irq_flags = f; cyc_stb = s; last_cyc = l;
    instr_reti = r; instr_cfg_wr = w; reti_exec = x;
    @(negedge clk);
    compare();
  endtask

  task automatic chk_call(input bit v, input int idx, input string rq);
    chk(call_req == v, rq, call_req, v);
    if (v) begin
      chk(call_idx == 3'(idx), rq, call_idx, idx);
      chk(call_vec == 8'(3 + 8 * idx), rq, call_vec, 3 + 8 * idx);
    end
  endtask

  task automatic flush();
    step(5'h00, 1, 0, 0, 0, 0);
    step(5'h00, 0, 0, 0, 0, 1);
    step(5'h00, 0, 0, 0, 0, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, got 0 expected 1");
    finish_run();
  end

  initial begin
    rst_n = 0;
    irq_flags = 0; cyc_stb = 0; last_cyc = 0; instr_reti = 0;
    instr_cfg_wr = 0; reti_exec = 0; en_reg = 8'h9F; pri_reg = 8'h00;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk(call_req == 0, "R1", call_req, 0);
    chk(act_lvl == 0, "R1", act_lvl, 0);
    rst_n = 1;
    step(5'h1F, 0, 1, 0, 0, 0);
    chk_call(0, 0, "R1");

    // R2: sample then poll
    tag = "R2";
    step(5'h01, 1, 1, 0, 0, 0);
    chk_call(0, 0, "R2");
    step(5'h00, 1, 1, 0, 0, 0);
    chk_call(1, 0, "R2");
    step(5'h00, 0, 1, 0, 0, 0);
    chk_call(0, 0, "R11");
    chk(act_lvl == 2'b01, "R10", act_lvl, 1);
    step(5'h00, 0, 0, 0, 0, 1);
    chk(act_lvl == 2'b00, "R10", act_lvl, 0);

    // R3: global off, then per-source off
    tag = "R3";
    en_reg = 8'h1F;
    step(5'h02, 1, 1, 0, 0, 0);
    step(5'h00, 1, 1, 0, 0, 0);
    chk_call(0, 0, "R3");
    en_reg = 8'h9D;
    step(5'h02, 1, 1, 0, 0, 0);
    step(5'h00, 1, 1, 0, 0, 0);
    chk_call(0, 0, "R3");
    en_reg = 8'h9F;

    // R4 and R6: blocked by a middle cycle, flag dropped before the next sample
    tag = "R4";
    step(5'h04, 1, 1, 0, 0, 0);
    step(5'h00, 1, 0, 0, 0, 0);
    chk_call(0, 0, "R4");
    tag = "R6";
    step(5'h00, 1, 1, 0, 0, 0);
    chk_call(0, 0, "R6");
    chk(act_lvl == 0, "R6", act_lvl, 0);

    // R5: blocked by return and by config write, then a held flag goes through
    tag = "R5";
    step(5'h08, 1, 1, 0, 0, 0);
    step(5'h08, 1, 1, 1, 0, 0);
    chk_call(0, 0, "R5");
    step(5'h08, 1, 1, 0, 1, 0);
    chk_call(0, 0, "R5");
    step(5'h00, 1, 1, 0, 0, 0);
    chk_call(1, 3, "R5");
    flush();

    // R7: high level wins over a lower index at low level
    tag = "R7";
    pri_reg = 8'h08;
    step(5'h09, 1, 1, 0, 0, 0);
    step(5'h00, 1, 1, 0, 0, 0);
    chk_call(1, 3, "R7");
    chk(act_lvl == 2'b10, "R7", act_lvl, 2);
    flush();

    // R8: tie order
    tag = "R8";
    pri_reg = 8'h00;
    step(5'h1E, 1, 1, 0, 0, 0);
    step(5'h00, 1, 1, 0, 0, 0);
    chk_call(1, 1, "R8");
    flush();
    step(5'h10, 1, 1, 0, 0, 0);
    step(5'h00, 1, 1, 0, 0, 0);
    chk_call(1, 4, "R8");
    flush();

    // R9: nesting
    tag = "R9";
    pri_reg = 8'h04;
    step(5'h01, 1, 1, 0, 0, 0);
    step(5'h02, 1, 1, 0, 0, 0);
    chk_call(1, 0, "R9");
    step(5'h00, 1, 1, 0, 0, 0);
    chk_call(0, 0, "R9");
    step(5'h04, 1, 1, 0, 0, 0);
    step(5'h04, 1, 1, 0, 0, 0);
    chk_call(1, 2, "R9");
    chk(act_lvl == 2'b11, "R10", act_lvl, 3);
    step(5'h00, 1, 1, 0, 0, 0);
    chk_call(0, 0, "R9");
    step(5'h00, 0, 0, 0, 0, 1);
    chk(act_lvl == 2'b01, "R10", act_lvl, 1);
    step(5'h00, 0, 0, 0, 0, 1);
    chk(act_lvl == 2'b00, "R10", act_lvl, 0);

    // random run against the model
    tag = "R11";
    for (int k = 0; k < 4000; k++) begin
      if (k % 500 == 0) begin
        en_reg  = 8'($urandom) | 8'h80;
        pri_reg = 8'($urandom);
      end
      step(5'($urandom), ($urandom % 3) == 0, ($urandom % 4) != 0,
           ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 6) == 0);
    end

    finish_run();
  end

endmodule